// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Word Link

This block moves single data words between a command-side master and a small register-bank slave. The two sides share no clock relationship. They coordinate only through one request line and one acknowledge line. The address, the direction bit and the write word travel on a parallel path. That path never needs synchronising, because the handshake guarantees it is stable whenever the other side samples it.

A client hands the master one command through a ready/valid port. The master places the address and direction (and the write word) on the link. It lets them settle for a fixed number of its own cycles, then raises request. The slave notices request through a two-flop synchroniser. It then either stores the write word or loads the addressed word onto the return path, and raises acknowledge. The master sees acknowledge through its own two-flop synchroniser and drops request, taking in the returned word on a read. The slave sees request fall and drops acknowledge. Once the master sees acknowledge low, it pulses done and becomes ready again.

All cycle counts below assume both clocks run at the same rate, as they do in the bench. Each crossing costs two receiving-side cycles plus one cycle for the receiving state machine to react.

Top module: `hs4_link`

## Requirements
- R1: While reset is held low at a clock edge, cmd_ready is high, link_req, link_ack and done are low, and rd_data, link_addr and link_write are zero.
- R2: A command is taken at an edge where cmd_valid and cmd_ready are both high. Its address and direction appear on link_addr and link_write after that edge and stay unchanged until the next command is taken. Command inputs at any other edge have no effect on the link.
- R3: link_req rises exactly SETTLE_CYC cycles after the accepting edge, while link_ack is low.
- R4: link_ack rises three cycles after link_req rises, and link_req is still high at that point.
- R5: link_req falls three cycles after link_ack rises. On a read, rd_data takes the returned word at that same edge. A write leaves rd_data unchanged.
- R6: link_ack falls three cycles after link_req falls.
- R7: done is high for exactly one cycle, starting three cycles after link_ack falls. cmd_ready is high again from that same edge, which gives a back-to-back period of SETTLE_CYC+13 cycles.
- R8: cmd_ready is low from the accepting edge until done, and link_req and link_ack are both low whenever cmd_ready is high.
- R9: cmd_write=1 stores cmd_wdata in the slave word chosen by cmd_addr (2^ADDR_W words, all zero after reset). cmd_write=0 returns the most recently stored word at that address.
- R10: The word the slave returns does not change while link_ack stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master-side clock |
| rst_m_n | input | 1 | Master-side synchronous active-low reset |
| clk_s | input | 1 | Slave-side clock |
| rst_s_n | input | 1 | Slave-side synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_wdata | input | DATA_W | Word to write |
| done | output | 1 | One-cycle pulse when a transaction has fully closed |
| rd_data | output | DATA_W | Word captured by the latest read |
| link_req | output | 1 | Request line, master to slave |
| link_ack | output | 1 | Acknowledge line, slave to master |
| link_addr | output | ADDR_W | Address on the link |
| link_write | output | 1 | Direction on the link |

## Verification
The bench targets the exact cycle of every handshake edge after acceptance. If the settle count is off by one, link_req moves a cycle early or late. If a synchroniser stage is missing or doubled, each later edge shifts. If the master reacts to acknowledge before its synchroniser has filled, link_req falls too early and the read capture is wrong. Back-to-back commands with cmd_valid held high check that nothing is accepted while busy and that the link address does not follow inputs that change mid-transaction. Reads of written, overwritten and never-written words catch a slave that returns a stale word or stores to the wrong address.

// File: rtl/hs4_pkg.sv
// Shared state encodings for the four-phase link.
package hs4_pkg;

    // Master sequencing: idle, address settling, request high, request low.
    typedef enum logic [1:0] {
        M_IDLE   = 2'd0,
        M_SETTLE = 2'd1,
        M_REQ_HI = 2'd2,
        M_REQ_LO = 2'd3
    } mst_state_t;

    // Slave sequencing: waiting for request, holding acknowledge.
    typedef enum logic {
        S_WAIT = 1'b0,
        S_HOLD = 1'b1
    } slv_state_t;

endpackage

// File: rtl/hs4_sync2.sv
// Two-flop synchroniser for one handshake line.
// Assumes the input is a single-bit level that changes at most once per handshake phase.
module hs4_sync2 #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Shift the asynchronous level through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RESET_VAL;
            q    <= RESET_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hs4_master.sv
// Link master: takes one command, drives address/direction/data, waits
// SETTLE_CYC cycles, then runs request high/low against the synchronised
// acknowledge. Assumes ack_sync is already synchronised into clk.
module hs4_master
    import hs4_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              req,
    input  logic              ack_sync,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int              CNT_W    = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    mst_state_t       state;
    logic [CNT_W-1:0] cnt;

    // Ready only while idle.
    assign cmd_ready = (state == M_IDLE);

    // Sequence one transaction through settle and both request phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= M_IDLE;
            cnt       <= '0;
            req       <= 1'b0;
            done      <= 1'b0;
            rd_data   <= '0;
            bus_addr  <= '0;
            bus_write <= 1'b0;
            bus_wdata <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                M_IDLE: begin
                    if (cmd_valid) begin
                        bus_addr  <= cmd_addr;
                        bus_write <= cmd_write;
                        bus_wdata <= cmd_wdata;
                        cnt       <= '0;
                        state     <= M_SETTLE;
                    end
                end
                M_SETTLE: begin
                    if (cnt == CNT_LAST) begin
                        req   <= 1'b1;
                        state <= M_REQ_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_REQ_HI: begin
                    if (ack_sync) begin
                        req <= 1'b0;
                        if (!bus_write) begin
                            rd_data <= bus_rdata;
                        end
                        state <= M_REQ_LO;
                    end
                end
                M_REQ_LO: begin
                    if (!ack_sync) begin
                        done  <= 1'b1;
                        state <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs4_slave.sv
// Link slave: a bank of 2**ADDR_W words. On a synchronised request it
// stores the write word or loads the read word, raises acknowledge, and
// holds the read word until it sees request fall. Assumes the address,
// direction and write word are stable while req_sync is high.
module hs4_slave
    import hs4_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    slv_state_t        state;
    logic [DATA_W-1:0] bank [DEPTH];
    logic              take;

    // A new request is being served this cycle.
    assign take = (state == S_WAIT) && req_sync;

    // Word storage, cleared on reset, written when a write request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank[i] <= '0;
            end
        end else if (take && bus_write) begin
            bank[bus_addr] <= bus_wdata;
        end
    end

    // Acknowledge sequencing and read-word hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_WAIT;
            ack       <= 1'b0;
            bus_rdata <= '0;
        end else begin
            unique case (state)
                S_WAIT: begin
                    if (req_sync) begin
                        ack <= 1'b1;
                        if (!bus_write) begin
                            bus_rdata <= bank[bus_addr];
                        end
                        state <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (!req_sync) begin
                        ack   <= 1'b0;
                        state <= S_WAIT;
                    end
                end
                default: state <= S_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/hs4_link.sv
// Top: master and slave joined by request/acknowledge, each line crossing
// into the receiving clock through a two-flop synchroniser. The parallel
// address/data path crosses unsynchronised, relying on the handshake.
module hs4_link #(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              clk_s,
    input  logic              rst_s_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              link_req,
    output logic              link_ack,
    output logic [ADDR_W-1:0] link_addr,
    output logic              link_write
);
    logic [DATA_W-1:0] wdata_bus;
    logic [DATA_W-1:0] rdata_bus;
    logic              req_at_slave;
    logic              ack_at_master;

    hs4_master #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_master (
        .clk       (clk_m),
        .rst_n     (rst_m_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .done      (done),
        .rd_data   (rd_data),
        .bus_addr  (link_addr),
        .bus_write (link_write),
        .bus_wdata (wdata_bus),
        .req       (link_req),
        .ack_sync  (ack_at_master),
        .bus_rdata (rdata_bus)
    );

    hs4_sync2 u_req_sync (
        .clk   (clk_s),
        .rst_n (rst_s_n),
        .d     (link_req),
        .q     (req_at_slave)
    );

    hs4_sync2 u_ack_sync (
        .clk   (clk_m),
        .rst_n (rst_m_n),
        .d     (link_ack),
        .q     (ack_at_master)
    );

    hs4_slave #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_slave (
        .clk       (clk_s),
        .rst_n     (rst_s_n),
        .req_sync  (req_at_slave),
        .bus_addr  (link_addr),
        .bus_write (link_write),
        .bus_wdata (wdata_bus),
        .ack       (link_ack),
        .bus_rdata (rdata_bus)
    );
endmodule

// File: rtl/hs4_link_chk.sv
// Protocol checker for the link, sampled on the master clock. Assumes both
// sides share reset release; bound into every hs4_link instance.
module hs4_link_chk #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ack,
    input logic [ADDR_W-1:0] addr,
    input logic              wr,
    input logic [DATA_W-1:0] rdata,
    input logic              done,
    input logic              ready
);
    // R2: link address and direction do not move during a handshake.
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req || ack) |-> ($stable(addr) && $stable(wr)));

    // R3: request rises only while acknowledge is low.
    a_r3_req_rise_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> !ack);

    // R4: acknowledge rises only while request is high.
    a_r4_ack_rise_req_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> req);

    // R5: request falls only after acknowledge is high.
    a_r5_req_fall_ack_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> ack);

    // R6: acknowledge falls only after request is low.
    a_r6_ack_fall_req_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !req);

    // R7: done lasts a single cycle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an idle master has both handshake lines low.
    a_r8_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!req && !ack));

    // R10: returned word is held while acknowledge stays high.
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(rdata));
endmodule

bind hs4_link hs4_link_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk   (clk_m),
    .rst_n (rst_m_n),
    .req   (link_req),
    .ack   (link_ack),
    .addr  (link_addr),
    .wr    (link_write),
    .rdata (rdata_bus),
    .done  (done),
    .ready (cmd_ready)
);

// File: tb/sim_hs4_link.sv
// Bench: both sides on one 125 MHz clock; a behavioural timeline model
// predicts every output and is compared on each falling edge.
module sim_hs4_link;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int W  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_write = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_ready, done, link_req, link_ack, link_write;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] link_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hs4_link #(.ADDR_W(AW), .DATA_W(DW), .SETTLE_CYC(W)) u0 (
        .clk_m(clk), .rst_m_n(rst_n), .clk_s(clk), .rst_s_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .done(done),
        .rd_data(rd_data), .link_req(link_req), .link_ack(link_ack),
        .link_addr(link_addr), .link_write(link_write)
    );

    // Reference timeline state
    bit            m_busy;
    int            m_k;
    logic [AW-1:0] m_addr;
    logic          m_write;
    logic [DW-1:0] m_mem [1 << AW];
    logic [DW-1:0] m_rd;
    bit            m_done;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance the model by one clock, from inputs set on the previous falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_k = 0; m_addr = '0; m_write = 0; m_rd = '0; m_done = 0;
            for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_k++;
                if (m_k == W + 6 && !m_write) m_rd = m_mem[m_addr];
                if (m_k == W + 12) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (cmd_valid) begin
                m_busy = 1; m_k = 0; m_addr = cmd_addr; m_write = cmd_write;
                if (cmd_write) m_mem[cmd_addr] = cmd_wdata;
            end
        end
    end

    // Compare every output against the model between edges.
    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                chk("R1 ready", cmd_ready, 1);
                chk("R1 req", link_req, 0);
                chk("R1 ack", link_ack, 0);
                chk("R1 done", done, 0);
                chk("R1 rd_data", rd_data, 0);
                chk("R1 link_addr", link_addr, 0);
            end else begin
                chk("R8 ready", cmd_ready, !m_busy);
                chk("R3/R5 req", link_req, m_busy && m_k >= W && m_k < W + 6);
                chk("R4/R6 ack", link_ack, m_busy && m_k >= W + 3 && m_k < W + 9);
                chk("R7 done", done, m_done);
                chk("R2 link_addr", link_addr, m_addr);
                chk("R2 link_write", link_write, m_write);
                chk("R5 rd_data", rd_data, m_rd);
                if (m_done && !m_write) chk("R9/R10 read word", rd_data, m_rd);
            end
        end
    end

    // Offer one command and return on the falling edge after it is taken.
    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit was_ready;
        cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
        do begin
            was_ready = cmd_ready;
            @(posedge clk);
        end while (!was_ready);
        @(negedge clk);
    endtask

    // Drop valid and scramble the command fields for some cycles.
    task automatic idle(input int n);
        cmd_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            cmd_write = 1'($urandom);
            cmd_addr  = AW'($urandom);
            cmd_wdata = DW'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: never-written word reads zero.
        issue(0, 3'd5, '0);
        idle(2 * (W + 13));
        // R9: write then read back, with scrambled inputs while busy (R2).
        issue(1, 3'd5, 16'hBEEF);
        idle(W + 16);
        issue(1, 3'd2, 16'h1234);
        idle(W + 16);
        issue(0, 3'd5, '0);
        idle(W + 16);
        issue(0, 3'd2, '0);
        idle(W + 16);
        issue(0, 3'd7, '0);
        idle(W + 16);
        // R7/R8: back-to-back with valid held high.
        for (int i = 0; i < (1 << AW); i++) issue(1, AW'(i), DW'(16'hA000 + i * 17));
        issue(1, 3'd3, 16'h5A5A);
        for (int i = 0; i < (1 << AW); i++) issue(0, AW'(i), '0);
        idle(W + 16);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule